// File: doc/BRIEF.md
# Tree Reduction Sequencer

This block keeps a bank of 32-bit partial sums, one per lane, and folds a chosen prefix of that bank into a single total. The folding works by repeated halving. In each step, every lane in the lower part of the active range adds the value held by the lane a fixed distance above it. The active count is then cut roughly in half. When only one element is left, lane 0 holds the total. The step is then reported with a one-cycle done pulse, and the total appears on a held result output.

The host fills lanes through a simple write port while the block is idle. It then pulses start with the number of active lanes and picks one of two halving rules.

- **Floor rule:** the count becomes `count/2`. When the count is odd, lane 0 absorbs the element that has no partner.
- **Ceiling rule:** the count becomes `(count+1)/2`. Every lane in the upper part passes its value down to lane `index-half`.

Each step commits all of its additions on a single clock edge. A step only ever reads values from before that edge, which gives a barrier between steps at no extra cost. The bank is left holding the partial sums, so a later start without a reload reduces those values.

Top module: `tree_reduce`

## Requirements
- R1: While idle, `ld_en` writes `ld_data` into lane `ld_idx`. An index at or above NUM_LANES writes nothing. A write in the same cycle as an accepted start is included in that run.
- R2: A start while idle with count c (1..NUM_LANES) gives exactly one cycle of `done` high. At that point `result` equals the sum, modulo 2^32, of lanes 0..c-1 as they were when the run began.
- R3: With `ceil_mode`=0, each step maps c to floor(c/2), and an odd c folds lane c-1 into lane 0. `done` is high k cycles after the start edge, where k is the number of such steps needed to reach 1 (6 for c=100).
- R4: With `ceil_mode`=1, each step maps c to ceil(c/2). `done` follows after the number of such steps needed to reach 1 (7 for c=100).
- R5: A count of 0 or 1 finishes one cycle after start, and `result` is lane 0.
- R6: A count above NUM_LANES is treated as NUM_LANES.
- R7: While a run is in progress, start pulses and lane writes are ignored. This includes the cycle of the final step.
- R8: `result` keeps its value from one done pulse until the next.
- R9: Additions wrap modulo 2^32.
- R10: After reset, `done` and `result` are 0, the block is idle and every lane holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Lane write enable |
| ld_idx | input | $clog2(NUM_LANES) | Lane written |
| ld_data | input | 32 | Value written |
| start | input | 1 | Begin a reduction (one-cycle pulse) |
| count | input | $clog2(NUM_LANES+1) | Number of active lanes |
| ceil_mode | input | 1 | 0 selects the floor rule, 1 selects the ceiling rule |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Total from the latest run |

## Verification
Two events can land in the same clock. The first case is a lane write arriving together with an accepted start. The bench drives both in one cycle and expects the written value to be part of the total. The second case is a new start arriving during the final step, when done is about to rise. The bench drives that start in the cycle before done appears, and a cycle-accurate behavioural model judges it: the start must leave no trace, and the completion must still land in its expected cycle with the unchanged total.

// File: rtl/tr_pkg.sv
package tr_pkg;

    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        HALVE_FLOOR = 1'b0,
        HALVE_CEIL  = 1'b1
    } halve_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic step_en;
        logic fold_en;
        logic finish;
    } step_ctl_t;

endpackage

// File: rtl/tr_seq_ctrl.sv
module tr_seq_ctrl
    import tr_pkg::*;
#(
    parameter int NUM_LANES = 100,
    parameter int CNT_W     = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    input  logic             ceil_mode,
    output logic             busy,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] half,
    output step_ctl_t        ctl,
    output logic             done
);

    localparam logic [CNT_W-1:0] LANE_MAX = CNT_W'(NUM_LANES);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    seq_state_e       state_q;
    halve_mode_e      mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_load;
    logic [CNT_W:0]   cnt_ext;
    logic [CNT_W:0]   half_ext;
    logic             done_q;

    // Clamp the requested count into 1..NUM_LANES.
    always_comb begin
        if (count == '0) begin
            cnt_load = ONE;
        end else if (count > LANE_MAX) begin
            cnt_load = LANE_MAX;
        end else begin
            cnt_load = count;
        end
    end

    // Halving rule, computed once for the whole bank.
    always_comb begin
        cnt_ext = {1'b0, cnt_q};
        if (mode_q == HALVE_CEIL) begin
            half_ext = (cnt_ext + (CNT_W+1)'(1)) >> 1;
        end else begin
            half_ext = cnt_ext >> 1;
        end
    end

    assign half = half_ext[CNT_W-1:0];
    assign busy = (state_q == ST_RUN);
    assign cnt  = cnt_q;

    always_comb begin
        ctl.step_en = busy && (cnt_q > ONE);
        ctl.fold_en = ctl.step_en && (mode_q == HALVE_FLOOR) && cnt_q[0];
        ctl.finish  = busy && (!ctl.step_en || (half == ONE));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= HALVE_FLOOR;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= ctl.finish;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cnt_q   <= cnt_load;
                        mode_q  <= halve_mode_e'(ceil_mode);
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (ctl.step_en) begin
                        cnt_q <= half;
                    end
                    if (ctl.finish) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done = done_q;

endmodule

// File: rtl/tr_lane_bank.sv
module tr_lane_bank
    import tr_pkg::*;
#(
    parameter int NUM_LANES = 100,
    parameter int CNT_W     = 7,
    parameter int IDX_W     = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  word_t            wr_data,
    input  step_ctl_t        ctl,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] half,
    output word_t            head_next
);

    logic [NUM_LANES-1:0][WORD_W-1:0] lanes;
    logic [CNT_W-1:0]                 orphan_idx;
    logic [CNT_W:0]                   half_ext;
    logic [CNT_W:0]                   cnt_ext;

    assign orphan_idx = cnt - CNT_W'(1);
    assign half_ext   = {1'b0, half};
    assign cnt_ext    = {1'b0, cnt};

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam logic [CNT_W:0]   POS  = (CNT_W+1)'(g);
        localparam logic [IDX_W-1:0] SLOT = IDX_W'(g);

        logic [CNT_W:0] pidx;
        logic           pair_en;
        word_t          partner;
        word_t          extra;
        word_t          sum_v;
        word_t          val_q;

        assign pidx    = POS + half_ext;
        assign pair_en = (POS < half_ext) && (pidx < cnt_ext);
        assign partner = pair_en ? lanes[pidx] : '0;

        if (g == 0) begin : g_head
            assign extra     = ctl.fold_en ? lanes[orphan_idx] : '0;
            assign head_next = ctl.step_en ? sum_v : val_q;
        end else begin : g_body
            assign extra = '0;
        end

        // Old values only: every operand is a register output.
        assign sum_v = val_q + partner + extra;

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q <= '0;
            end else if (ctl.step_en) begin
                val_q <= sum_v;
            end else if (wr_en && (wr_idx == SLOT)) begin
                val_q <= wr_data;
            end
        end

        assign lanes[g] = val_q;
    end

endmodule

// File: rtl/tree_reduce.sv
module tree_reduce
    import tr_pkg::*;
#(
    parameter  int NUM_LANES = 100,
    localparam int IDX_W     = $clog2(NUM_LANES),
    localparam int CNT_W     = $clog2(NUM_LANES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [31:0]      ld_data,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    input  logic             ceil_mode,
    output logic             done,
    output logic [31:0]      result
);

    logic             run_busy;
    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] run_half;
    step_ctl_t        run_ctl;
    word_t            head_next;
    word_t            result_q;

    tr_seq_ctrl #(
        .NUM_LANES (NUM_LANES),
        .CNT_W     (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .count     (count),
        .ceil_mode (ceil_mode),
        .busy      (run_busy),
        .cnt       (run_cnt),
        .half      (run_half),
        .ctl       (run_ctl),
        .done      (done)
    );

    tr_lane_bank #(
        .NUM_LANES (NUM_LANES),
        .CNT_W     (CNT_W),
        .IDX_W     (IDX_W)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (ld_en && !run_busy),
        .wr_idx    (ld_idx),
        .wr_data   (ld_data),
        .ctl       (run_ctl),
        .cnt       (run_cnt),
        .half      (run_half),
        .head_next (head_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
        end else if (run_ctl.finish) begin
            result_q <= head_next;
        end
    end

    assign result = result_q;

endmodule

// File: rtl/tree_reduce_chk.sv
module tree_reduce_chk #(
    parameter  int NUM_LANES = 100,
    localparam int CNT_W     = $clog2(NUM_LANES + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             done,
    input logic             busy,
    input logic [CNT_W-1:0] cnt,
    input logic [31:0]      result
);

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    done_after_run_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    // R3
    count_shrink_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && (cnt > CNT_W'(1))) |=> (cnt < $past(cnt)));

    // R6
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> ((cnt >= CNT_W'(1)) && (cnt <= CNT_W'(NUM_LANES))));

endmodule

bind tree_reduce tree_reduce_chk #(.NUM_LANES(NUM_LANES)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .done   (done),
    .busy   (run_busy),
    .cnt    (run_cnt),
    .result (result)
);

// File: tb/test_tree_reduce.sv
module test_tree_reduce;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 100;
    localparam int IW         = $clog2(N);
    localparam int CW         = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_en = 1'b0;
    logic [IW-1:0] ld_idx = '0;
    logic [31:0]   ld_data = '0;
    logic          start = 1'b0;
    logic [CW-1:0] count = '0;
    logic          ceil_mode = 1'b0;
    logic          done;
    logic [31:0]   result;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    finished = 0;
    string cur_req = "R10";

    // behavioural reference state
    bit [31:0] m_bank [N];
    bit [31:0] host   [N];
    bit        m_busy, m_done, m_ceil;
    bit [31:0] m_result;
    int        m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    tree_reduce #(.NUM_LANES(N)) i_tree_reduce (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .start(start), .count(count), .ceil_mode(ceil_mode),
        .done(done), .result(result)
    );

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int clamp(int c);
        if (c == 0) return 1;
        if (c > N)  return N;
        return c;
    endfunction

    function automatic int steps_for(int c_in, bit ce);
        int c = clamp(c_in);
        int k = 0;
        while (c > 1) begin
            c = ce ? (c + 1) / 2 : c / 2;
            k++;
        end
        return (k == 0) ? 1 : k;
    endfunction

    function automatic bit [31:0] host_sum(int c_in);
        bit [31:0] s = 0;
        for (int i = 0; i < clamp(c_in); i++) s += host[i];
        return s;
    endfunction

    task automatic model_step();
        m_done = 0;
        if (!m_busy) begin
            if (ld_en && (int'(ld_idx) < N)) m_bank[ld_idx] = ld_data;
            if (start) begin
                m_cnt  = clamp(int'(count));
                m_ceil = ceil_mode;
                m_busy = 1;
            end
        end else begin
            if (m_cnt > 1) begin
                int h;
                if (!m_ceil) begin
                    if (m_cnt % 2 == 1) m_bank[0] += m_bank[m_cnt-1];
                    h = m_cnt / 2;
                    for (int i = 0; i < h; i++) m_bank[i] += m_bank[i+h];
                end else begin
                    h = (m_cnt + 1) / 2;
                    for (int i = h; i < m_cnt; i++) m_bank[i-h] += m_bank[i];
                end
                m_cnt = h;
            end
            if (m_cnt == 1) begin
                m_done   = 1;
                m_result = m_bank[0];
                m_busy   = 0;
            end
        end
    endtask

    // One clock: advance the model, clock the design, compare at the falling edge.
    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(done === m_done, cur_req, "done vs model", longint'(done), longint'(m_done));
        check(result === m_result, cur_req, "result vs model", longint'(result), longint'(m_result));
    endtask

    task automatic load_lane(int idx, bit [31:0] val);
        ld_en = 1; ld_idx = IW'(idx); ld_data = val;
        if (idx < N) host[idx] = val;
        cycle();
        ld_en = 0;
    endtask

    task automatic load_all(bit [31:0] base, bit [31:0] stride);
        for (int i = 0; i < N; i++) load_lane(i, base + stride * i);
    endtask

    task automatic run_reduce(int c, bit ce, string tag, bit chk_total,
                              bit [31:0] exp_total, bit inject);
        int k = 0;
        bit seen = 0;
        int exp_k = steps_for(c, ce);
        cur_req = tag;
        start = 1; count = CW'(c); ceil_mode = ce;
        cycle();
        start = 0;
        while (!seen && k < 300) begin
            if (inject && k == 2) begin
                start = 1; count = CW'(2);
                ld_en = 1; ld_idx = IW'(N-1); ld_data = 32'hDEAD_0001;
            end
            if (inject && k == 3) begin
                start = 0; ld_en = 0;
            end
            if (inject && k == exp_k - 1) begin
                start = 1; count = CW'(1);
            end
            cycle();
            k++;
            start = 0; ld_en = 0;
            if (done) seen = 1;
        end
        check(seen && k == exp_k, tag, "cycles to done", k, exp_k);
        if (chk_total) check(result == exp_total, tag, "total", result, exp_total);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin m_bank[i] = 0; host[i] = 0; end
        m_busy = 0; m_done = 0; m_ceil = 0; m_result = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R10: reset state
        check(done === 1'b0, "R10", "done after reset", done, 0);
        check(result === 32'd0, "R10", "result after reset", result, 0);
        run_reduce(N, 0, "R10", 1, 32'd0, 0);

        // R2, R3: full bank, floor rule (100 -> 6 steps)
        load_all(32'd1, 32'd3);
        load_lane(N + 5, 32'hFFFF_0000);       // R1: out-of-range write ignored
        run_reduce(N, 0, "R3", 1, host_sum(N), 0);
        check(result == host_sum(N), "R1", "total after bad index", result, host_sum(N));

        // R8: result held while idle
        for (int i = 0; i < 5; i++) begin
            cur_req = "R8";
            cycle();
            check(result == host_sum(N), "R8", "held result", result, host_sum(N));
        end

        // R4: ceiling rule (100 -> 7 steps)
        load_all(32'd7, 32'd11);
        run_reduce(N, 1, "R4", 1, host_sum(N), 0);

        // R3: odd counts under floor rule
        load_all(32'd5, 32'd2);
        run_reduce(7, 0, "R3", 1, host_sum(7), 0);
        load_all(32'd9, 32'd13);
        run_reduce(37, 0, "R3", 1, host_sum(37), 0);
        load_all(32'd4, 32'd6);
        run_reduce(37, 1, "R4", 1, host_sum(37), 0);

        // R5: count 0 and count 1
        load_lane(0, 32'd1234);
        run_reduce(0, 0, "R5", 1, 32'd1234, 0);
        load_lane(0, 32'd77);
        run_reduce(1, 1, "R5", 1, 32'd77, 0);

        // R6: count above the bank size
        load_all(32'd2, 32'd1);
        run_reduce(127, 0, "R6", 1, host_sum(N), 0);

        // R9: wrap-around
        for (int i = 0; i < 4; i++) load_lane(i, 32'hFFFF_FFF0 + i);
        run_reduce(4, 0, "R9", 1, host_sum(4), 0);

        // R7: start and write while busy, including the final-step cycle
        load_all(32'd3, 32'd5);
        run_reduce(N, 0, "R7", 1, host_sum(N), 1);
        // bank left holding partial sums; model compares every cycle
        run_reduce(N, 1, "R7", 0, 32'd0, 0);

        // R1: write in the same cycle as start
        cur_req = "R1";
        ld_en = 1; ld_idx = '0; ld_data = 32'hCAFE_0042;
        run_reduce(1, 0, "R1", 1, 32'hCAFE_0042, 0);

        // R2: short even count
        load_all(32'd100, 32'd1);
        run_reduce(2, 0, "R2", 1, host_sum(2), 0);

        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule